// File: doc/BRIEF.md
# Programmable Field Timing Sequencer

This block picks which stored field-timing entry is active in each vertical period. Software loads a cycle length and up to seven 5-bit field selectors through a small register write port. The block then steps through the selectors in order, moving one slot on every falling edge of the vertical sync input (VD). After the last counted slot it returns to the first slot. The active selector goes to the downstream vertical timing logic. A one-cycle strobe marks each time the output index is refreshed.

Register writes can take effect in two ways. In immediate mode they apply at once. In VD-synchronized mode they are held in a shadow copy and applied together on the second VD falling edge after the write. Only a write to the second list register rewinds the sequence to slot zero. In synchronized mode that rewind is also held until the settings are applied.

Top module: `fieldSequencer`

## Requirements
- R1: After an active-low reset, `fieldIdx` is 0, `fieldChange` is 0, the cycle length is 1, every selector is 0 and the position is slot 0.
- R2: Address 0 writes the cycle length from `wrData[2:0]`. Address 1 writes slots 0 to 4, with slot k taken from `wrData[5k+4:5k]`. Address 2 writes slot 5 from `wrData[4:0]` and slot 6 from `wrData[9:5]`.
- R3: Each VD falling edge (`vd` low in a cycle after it was high) advances the position by one slot. `fieldIdx` shows the selector of the current slot, starting from slot 0. The new value is visible in the cycle after the clock edge that sees the fall.
- R4: When the position reaches the last counted slot (cycle length minus 1), the next VD falling edge returns it to slot 0.
- R5: A cycle length of 0 acts as 1: the position stays on slot 0 and each VD fall still pulses `fieldChange`.
- R6: In immediate mode, a write to address 2 sets the position to slot 0 at that write's clock edge. This takes priority over a coincident VD fall.
- R7: Writes to address 0 or address 1 never change the position.
- R8: In immediate mode (`vdSyncMode` low during the write), written values drive `fieldIdx` from the next cycle.
- R9: In VD-synchronized mode (`vdSyncMode` high during the write), written values stay hidden until the second VD falling edge after the write. At that edge the whole shadow copy becomes active. The advance at that edge already uses the new cycle length.
- R10: In VD-synchronized mode, an address-2 write does not move the position at the write. It rewinds the position to slot 0 on the edge where the settings are applied, in place of that edge's advance.
- R11: `fieldChange` is high for exactly the cycles that follow an advance or a rewind, and low at all other times.
- R12: A rising edge of `vd`, or `vd` holding its level, leaves `fieldIdx` and the position unchanged.
- R13: A further synchronized write, while settings are still waiting, restarts the count of two falling edges from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 2 | Register address: 0 cycle length, 1 slots 0-4, 2 slots 5-6 |
| wrData | input | 25 | Register write data |
| vd | input | 1 | Vertical sync level, synchronous to clk |
| vdSyncMode | input | 1 | 1 = hold writes until the second VD fall, 0 = apply at once |
| fieldIdx | output | 5 | Selector of the active field slot |
| fieldChange | output | 1 | One-cycle pulse after each advance or rewind |

## Verification
Every result appears exactly one cycle after the clock edge that registers its cause. A VD fall driven before an edge shows its new index and strobe in the following cycle. An immediate write is likewise visible one cycle after its edge. A synchronized write shows nothing until one cycle after the edge that sees the second later fall. The bench drives inputs on the falling clock edge and samples both outputs on the next falling edge, so each comparison lands in the cycle its result is due. The bench's reference model is stepped once per clock with the same inputs, so the directed and random checks all keep to that one-cycle spacing.

// File: rtl/fieldSeqPkg.sv
`timescale 1ns/1ps
package fieldSeqPkg;
  localparam int SEL_W     = 5;
  localparam int NUM_SLOTS = 7;
  localparam int SLOTS_A   = 5;
  localparam int CNT_W     = 3;
  localparam int POS_W     = CNT_W;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = SLOTS_A * SEL_W;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIST_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIST_B = 2'd2;

  typedef enum logic [1:0] {
    ARM_IDLE   = 2'd0,
    ARM_FIRST  = 2'd1,
    ARM_SECOND = 2'd2
  } armState_t;

  typedef struct packed {
    logic wrCount;
    logic wrListA;
    logic wrListB;
    logic toActive;
    logic commit;
    logic advance;
    logic resetPos;
  } seqCtrl_t;

  function automatic logic [CNT_W-1:0] effCount(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? CNT_W'(1) : raw;
  endfunction
endpackage

// File: rtl/fieldSeqCtrl.sv
`timescale 1ns/1ps
module fieldSeqCtrl
  import fieldSeqPkg::*;
#(
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_BITS-1:0] wrAddr,
  input  logic                 vd,
  input  logic                 vdSyncMode,
  output seqCtrl_t             strb
);
  logic      vdPrev;
  logic      vdFall;
  armState_t armState;
  logic      pendReset;
  logic      hitCount, hitListA, hitListB, anyWrite, syncWrite, commitNow;

  always_comb begin
    vdFall    = vdPrev & ~vd;
    hitCount  = wrEn && (wrAddr == ADDR_BITS'(ADDR_COUNT));
    hitListA  = wrEn && (wrAddr == ADDR_BITS'(ADDR_LIST_A));
    hitListB  = wrEn && (wrAddr == ADDR_BITS'(ADDR_LIST_B));
    anyWrite  = hitCount | hitListA | hitListB;
    syncWrite = anyWrite & vdSyncMode;
    commitNow = vdFall && (armState == ARM_SECOND);

    strb.wrCount  = hitCount;
    strb.wrListA  = hitListA;
    strb.wrListB  = hitListB;
    strb.toActive = anyWrite & ~vdSyncMode;
    strb.commit   = commitNow;
    strb.resetPos = (hitListB & ~vdSyncMode) | (commitNow & pendReset);
    strb.advance  = vdFall & ~strb.resetPos;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vdPrev    <= 1'b0;
      armState  <= ARM_IDLE;
      pendReset <= 1'b0;
    end else begin
      vdPrev <= vd;
      if (syncWrite) begin
        armState  <= ARM_FIRST;
        pendReset <= hitListB | (pendReset && (armState != ARM_IDLE) && !commitNow);
      end else if (vdFall) begin
        unique case (armState)
          ARM_FIRST:  armState <= ARM_SECOND;
          ARM_SECOND: begin
            armState  <= ARM_IDLE;
            pendReset <= 1'b0;
          end
          default:    armState <= ARM_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fieldSeqData.sv
`timescale 1ns/1ps
module fieldSeqData
  import fieldSeqPkg::*;
#(
  parameter int SEL_BITS  = SEL_W,
  parameter int SLOTS     = NUM_SLOTS,
  parameter int FIRST_REG = SLOTS_A,
  parameter int CNT_BITS  = CNT_W,
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtrl_t             strb,
  input  logic [DATA_BITS-1:0] wrData,
  output logic [SEL_BITS-1:0]  fieldIdx,
  output logic                 fieldChange,
  output logic [CNT_BITS-1:0]  curPos
);
  localparam int MUX_N = 1 << CNT_BITS;

  logic [CNT_BITS-1:0] pendCount, actCount, nextLen;
  logic [CNT_BITS:0]   posInc;
  logic [SEL_BITS-1:0] selMux [MUX_N];

  for (genvar slot = 0; slot < MUX_N; slot++) begin : slotGen
    if (slot < SLOTS) begin : live
      localparam bool_inA = (slot < FIRST_REG);
      localparam int  LSB = bool_inA ? slot * SEL_BITS : (slot - FIRST_REG) * SEL_BITS;
      logic                hit;
      logic [SEL_BITS-1:0] pendQ, actQ;
      assign hit = bool_inA ? strb.wrListA : strb.wrListB;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pendQ <= '0;
          actQ  <= '0;
        end else begin
          if (hit) pendQ <= wrData[LSB +: SEL_BITS];
          if (hit && strb.toActive) actQ <= wrData[LSB +: SEL_BITS];
          else if (strb.commit)     actQ <= pendQ;
        end
      end
      assign selMux[slot] = actQ;
    end else begin : spare
      assign selMux[slot] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCount <= CNT_BITS'(1);
      actCount  <= CNT_BITS'(1);
    end else begin
      if (strb.wrCount) pendCount <= wrData[CNT_BITS-1:0];
      if (strb.wrCount && strb.toActive) actCount <= wrData[CNT_BITS-1:0];
      else if (strb.commit)              actCount <= pendCount;
    end
  end

  always_comb begin
    nextLen = effCount(strb.commit ? pendCount : actCount);
    posInc  = {1'b0, curPos} + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPos      <= '0;
      fieldChange <= 1'b0;
    end else begin
      fieldChange <= strb.resetPos | strb.advance;
      if (strb.resetPos)     curPos <= '0;
      else if (strb.advance) curPos <= (posInc >= {1'b0, nextLen}) ? '0 : posInc[CNT_BITS-1:0];
    end
  end

  assign fieldIdx = selMux[curPos];
endmodule

// File: rtl/fieldSequencer.sv
`timescale 1ns/1ps
module fieldSequencer
  import fieldSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              vd,
  input  logic              vdSyncMode,
  output logic [SEL_W-1:0]  fieldIdx,
  output logic              fieldChange
);
  seqCtrl_t         strb;
  logic [POS_W-1:0] curPos;

  fieldSeqCtrl #(.ADDR_BITS(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .vd(vd), .vdSyncMode(vdSyncMode), .strb(strb)
  );

  fieldSeqData #(
    .SEL_BITS(SEL_W), .SLOTS(NUM_SLOTS), .FIRST_REG(SLOTS_A),
    .CNT_BITS(CNT_W), .DATA_BITS(DATA_W)
  ) data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .fieldIdx(fieldIdx), .fieldChange(fieldChange), .curPos(curPos)
  );
endmodule

// File: rtl/fieldSeqChecker.sv
`timescale 1ns/1ps
module fieldSeqChecker
  import fieldSeqPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              vd,
  input logic              vdSyncMode,
  input logic [SEL_W-1:0]  fieldIdx,
  input logic              fieldChange,
  input logic [POS_W-1:0]  curPos
);
  logic vdSeen;
  logic sawFall;
  logic listBImm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vdSeen <= 1'b0;
    else       vdSeen <= vd;
  end

  assign sawFall  = vdSeen & ~vd;
  assign listBImm = wrEn && (wrAddr == ADDR_LIST_B) && !vdSyncMode;

  // R11
  change_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldChange |-> ($past(sawFall) || $past(listBImm)));

  // R12
  idle_holds_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sawFall && !wrEn) |=> ($stable(fieldIdx) && $stable(curPos)));

  // R6
  listb_rewinds_chk: assert property (@(posedge clk) disable iff (!rstN)
    listBImm |=> (curPos == '0 && fieldChange));

  // R4
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPos < POS_W'(NUM_SLOTS));

  // R9
  sync_write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && vdSyncMode && !sawFall) |=> (!fieldChange && $stable(fieldIdx)));
endmodule

bind fieldSequencer fieldSeqChecker chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .vd(vd),
  .vdSyncMode(vdSyncMode), .fieldIdx(fieldIdx), .fieldChange(fieldChange),
  .curPos(curPos)
);

// File: tb/fieldSequencer_test.sv
`timescale 1ns/1ps
module fieldSequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [24:0] wrData = '0;
  logic        vd = 1'b0;
  logic        vdSyncMode = 1'b0;
  logic [4:0]  fieldIdx;
  logic        fieldChange;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference model state
  logic [2:0] mActCnt, mPendCnt, mPos;
  logic [4:0] mActSel [7];
  logic [4:0] mPendSel [7];
  int         mStage;
  bit         mPendRst, mVdPrev, mChange;

  fieldSequencer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vd(vd), .vdSyncMode(vdSyncMode), .fieldIdx(fieldIdx), .fieldChange(fieldChange)
  );

  always #2.5 clk = ~clk;

  function automatic int lenOf(input logic [2:0] c);
    return (c == 3'd0) ? 1 : int'(c);
  endfunction

  function automatic logic [24:0] packA(input int f0, f1, f2, f3, f4);
    return 25'((f4 << 20) | (f3 << 15) | (f2 << 10) | (f1 << 5) | f0);
  endfunction

  function automatic logic [24:0] packB(input int f5, f6);
    return 25'((f6 << 5) | f5);
  endfunction

  task automatic modelReset();
    mActCnt = 3'd1; mPendCnt = 3'd1; mPos = 3'd0;
    for (int i = 0; i < 7; i++) begin mActSel[i] = 5'd0; mPendSel[i] = 5'd0; end
    mStage = 0; mPendRst = 1'b0; mVdPrev = 1'b0; mChange = 1'b0;
  endtask

  task automatic applyWrite(input logic [1:0] a, input logic [24:0] d, input bit toAct);
    if (a == 2'd0) begin
      mPendCnt = d[2:0];
      if (toAct) mActCnt = d[2:0];
    end else if (a == 2'd1) begin
      for (int k = 0; k < 5; k++) begin
        mPendSel[k] = d[5*k +: 5];
        if (toAct) mActSel[k] = d[5*k +: 5];
      end
    end else if (a == 2'd2) begin
      for (int k = 0; k < 2; k++) begin
        mPendSel[5+k] = d[5*k +: 5];
        if (toAct) mActSel[5+k] = d[5*k +: 5];
      end
    end
  endtask

  task automatic modelStep(input bit we, input logic [1:0] a, input logic [24:0] d,
                           input bit vdv, input bit sm);
    bit fall, commit, rewind;
    logic [2:0] oldPendCnt;
    logic [4:0] oldPend [7];
    int len;
    fall   = mVdPrev && !vdv;
    commit = fall && (mStage == 2);
    rewind = (we && a == 2'd2 && !sm) || (commit && mPendRst);
    oldPendCnt = mPendCnt;
    for (int i = 0; i < 7; i++) oldPend[i] = mPendSel[i];
    len = lenOf(commit ? mPendCnt : mActCnt);
    if (commit) begin
      mActCnt = oldPendCnt;
      for (int i = 0; i < 7; i++) mActSel[i] = oldPend[i];
    end
    if (we) applyWrite(a, d, !sm);
    if (rewind) mPos = 3'd0;
    else if (fall) mPos = (int'(mPos) + 1 >= len) ? 3'd0 : mPos + 3'd1;
    if (we && sm && a != 2'd3) begin
      mPendRst = (a == 2'd2) || (mPendRst && mStage != 0 && !commit);
      mStage = 1;
    end else if (fall) begin
      if (mStage == 1) mStage = 2;
      else if (mStage == 2) begin mStage = 0; mPendRst = 1'b0; end
    end
    mChange = rewind || fall;
    mVdPrev = vdv;
  endtask

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // one clock: drive at negedge, step model, sample at next negedge
  task automatic cyc(input bit we, input logic [1:0] a, input logic [24:0] d,
                     input bit vdv, input bit sm, input string req);
    wrEn = we; wrAddr = a; wrData = d; vd = vdv; vdSyncMode = sm;
    modelStep(we, a, d, vdv, sm);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " index"}, int'(fieldIdx), int'(mActSel[mPos]));
    check({req, " strobe"}, int'(fieldChange), int'(mChange));
  endtask

  task automatic wr(input logic [1:0] a, input logic [24:0] d, input bit sm, input string req);
    cyc(1'b1, a, d, vd, sm, req);
  endtask

  task automatic vdPulse(input string req);
    cyc(1'b0, 2'd0, '0, 1'b1, vdSyncMode, "R12 rise");
    cyc(1'b0, 2'd0, '0, 1'b0, vdSyncMode, req);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset index", int'(fieldIdx), 0);
    check("R1 reset strobe", int'(fieldChange), 0);
    rstN = 1'b1;
    cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, "R1");
    vdPulse("R1 length one");
    check("R1 holds slot0", int'(fieldIdx), 0);

    // immediate programming
    wr(2'd0, 25'd3, 1'b0, "R8 count");
    wr(2'd1, packA(3, 7, 11, 20, 31), 1'b0, "R2 listA");
    wr(2'd2, packB(9, 17), 1'b0, "R6 listB");
    check("R6 rewind strobe", int'(fieldChange), 1);
    check("R8 slot0 value", int'(fieldIdx), 3);
    cyc(1'b0, 2'd0, '0, 1'b0, 1'b0, "R11 quiet");
    check("R11 single pulse", int'(fieldChange), 0);
    vdPulse("R3 advance");
    check("R3 slot1", int'(fieldIdx), 7);
    vdPulse("R3 advance");
    check("R3 slot2", int'(fieldIdx), 11);
    vdPulse("R4 wrap");
    check("R4 wrap to slot0", int'(fieldIdx), 3);

    // count/listA writes do not move position
    vdPulse("R3");
    wr(2'd0, 25'd7, 1'b0, "R7 count write");
    check("R7 count keeps pos", int'(fieldIdx), 7);
    wr(2'd1, packA(3, 7, 11, 20, 31), 1'b0, "R7 listA write");
    check("R7 listA keeps pos", int'(fieldIdx), 7);
    for (int i = 0; i < 6; i++) vdPulse("R2 walk");
    check("R4 full wrap", int'(fieldIdx), 3);
    vdPulse("R3"); vdPulse("R3"); vdPulse("R3"); vdPulse("R3");
    vdPulse("R2 slot5");
    check("R2 slot5 field", int'(fieldIdx), 9);
    vdPulse("R2 slot6");
    check("R2 slot6 field", int'(fieldIdx), 17);

    // count zero
    wr(2'd0, 25'd0, 1'b0, "R5 count0");
    wr(2'd2, packB(9, 17), 1'b0, "R6");
    vdPulse("R5 hold");
    check("R5 stays slot0", int'(fieldIdx), 3);
    check("R5 strobe", int'(fieldChange), 1);

    // synchronized update
    wr(2'd0, 25'd3, 1'b0, "R8");
    wr(2'd2, packB(9, 17), 1'b0, "R6");
    wr(2'd1, packA(1, 2, 3, 4, 5), 1'b1, "R9 sync write");
    check("R9 hidden at write", int'(fieldIdx), 3);
    vdPulse("R9 first fall");
    check("R9 old after first", int'(fieldIdx), 7);
    vdPulse("R9 second fall");
    check("R9 new after second", int'(fieldIdx), 3);
    vdPulse("R9");
    check("R9 new slot0", int'(fieldIdx), 1);
    wr(2'd2, packB(6, 8), 1'b1, "R10 sync listB");
    check("R10 no rewind at write", int'(fieldChange), 0);
    vdPulse("R10 first fall");
    check("R10 advance not rewind", int'(fieldIdx), 2);
    vdPulse("R10 second fall");
    check("R10 rewind at commit", int'(fieldIdx), 1);

    // restart of the wait
    wr(2'd0, 25'd2, 1'b1, "R13 first");
    vdPulse("R13");
    check("R13 slot1", int'(fieldIdx), 2);
    wr(2'd0, 25'd1, 1'b1, "R13 rewrite");
    vdPulse("R13 not yet");
    check("R13 old length kept", int'(fieldIdx), 3);
    vdPulse("R13");
    vdPulse("R13 applied");
    check("R13 length one", int'(fieldIdx), 1);

    // constrained random
    begin
      int hold = 0;
      bit lvl = 1'b0;
      for (int n = 0; n < 4000; n++) begin
        bit we, sm;
        logic [1:0] a;
        if (hold == 0) begin lvl = ~lvl; hold = 2 + int'($urandom % 5); end
        hold--;
        we = ($urandom % 6) == 0;
        a  = 2'($urandom % 3);
        sm = $urandom % 2;
        cyc(we, a, 25'($urandom), lvl, sm, "R3 R4 R9 random");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule